// File: doc/BRIEF.md
# Header-Checked Frame Assembler

This block gathers a stream of bytes, each marked by a one-cycle valid strobe, into fixed-length frames. A frame has three parts in this order:

- a header of `HDR_BYTES` bytes,
- a body of `BODY_BYTES` bytes,
- a single check byte.

While the header arrives, a running XOR of its bytes is kept. When the final byte of a frame has been stored, the block raises an internal completion event and starts collecting the next frame at once.

One cycle after completion, the folded header value is compared with the check byte over all eight bits:

- On a match, the whole frame is presented on a wide parallel output together with a one-cycle valid pulse.
- On a mismatch, an error pulse is raised instead, and the pending forward of that frame is cancelled.

The block has no flow control toward its source. It expects frames to arrive back to back, aligned from reset.

Top module: `frame_hdr_check`

## Requirements
- R1: After reset, `out_valid` and `chk_err` are low and `out_frame` is all zeros.
- R2: Each cycle with `in_valid` high stores `in_byte` as the next byte of the current frame. Byte k of a frame appears at `out_frame[8k+7:8k]`. Cycles with `in_valid` low store nothing, whatever `in_byte` carries.
- R3: After `HDR_BYTES+BODY_BYTES+1` accepted bytes, the frame is complete. The next accepted byte becomes byte 0 of a new frame.
- R4: Bytes 0 to `HDR_BYTES-1` form the header. The following `BODY_BYTES` bytes form the body. The check byte sits at index `HDR_BYTES+BODY_BYTES`.
- R5: The expected check value is the XOR of the header bytes only, compared with the check byte on all 8 bits. Body bytes have no influence on the result.
- R6: On a match, `out_valid` is high for exactly one cycle, namely the second cycle after the clock edge that accepted the check byte. In that cycle `out_frame` holds the complete frame.
- R7: On a mismatch, `chk_err` is high for exactly one cycle with the same timing as R6. `out_valid` stays low, and `out_frame` keeps the last forwarded frame.
- R8: The header XOR restarts at every frame, so the result for one frame never depends on earlier frames.
- R9: `out_valid` and `chk_err` are never high together, and every completed frame yields exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Incoming byte |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| out_frame | output | 8*(HDR_BYTES+BODY_BYTES+1) | Last forwarded frame, byte k at bits 8k+7:8k |
| out_valid | output | 1 | One-cycle pulse for a forwarded frame |
| chk_err | output | 1 | One-cycle pulse for a frame whose check failed |

## Verification
The assertions watch the sequencing on every cycle:

- the byte position stays within the frame and holds still on idle cycles,
- each completion event is followed by exactly one of the two pulses one cycle later,
- the two pulses never coincide.

Only the bench scenarios can show whether the data is right. They cover the byte order in the forwarded frame, the XOR arithmetic, a corruption confined to bit 7, the insensitivity to body bytes and to idle-cycle garbage, and the absence of any carry-over of the accumulator from a failed frame into the next one.

// File: rtl/frame_hdr_pkg.sv
package frame_hdr_pkg;
  // Fold one header byte into the running check value.
  function automatic logic [7:0] hdr_fold(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

  // Full-byte comparison of computed value against the received check byte.
  function automatic logic chk_ok(input logic [7:0] calc, input logic [7:0] rx);
    return (calc == rx);
  endfunction
endpackage

// File: rtl/frame_collector.sv
module frame_collector #(
  parameter int HDR_BYTES  = 4,
  parameter int BODY_BYTES = 8,
  localparam int NBYTES = HDR_BYTES + BODY_BYTES + 1,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            in_byte,
  input  logic                  in_valid,
  output logic [IDX_W-1:0]      pos,
  output logic [NBYTES*8-1:0]   frame_q,
  output logic                  frame_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= in_valid && (pos == LAST);
      if (in_valid) pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  frame_q[i*8 +: 8] <= '0;
      else if (in_valid && pos == IDX_W'(i))       frame_q[i*8 +: 8] <= in_byte;
    end
  end
endmodule

// File: rtl/hdr_xor_unit.sv
module hdr_xor_unit
  import frame_hdr_pkg::*;
#(
  parameter int HDR_BYTES  = 4,
  parameter int BODY_BYTES = 8,
  localparam int NBYTES = HDR_BYTES + BODY_BYTES + 1,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_byte,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] pos,
  output logic [7:0]       hdr_acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_acc <= '0;
    else if (in_valid) begin
      if (pos == '0)                        hdr_acc <= in_byte;        // fresh frame
      else if (pos < IDX_W'(HDR_BYTES))     hdr_acc <= hdr_fold(hdr_acc, in_byte);
    end
  end
endmodule

// File: rtl/fwd_gate.sv
module fwd_gate
  import frame_hdr_pkg::*;
#(
  parameter int HDR_BYTES  = 4,
  parameter int BODY_BYTES = 8,
  localparam int NBYTES = HDR_BYTES + BODY_BYTES + 1,
  localparam int CHK_IDX = NBYTES - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic [NBYTES*8-1:0] frame_q,
  input  logic [7:0]          hdr_acc,
  output logic [NBYTES*8-1:0] out_frame,
  output logic                out_valid,
  output logic                chk_err
);
  logic match;
  assign match = chk_ok(hdr_acc, frame_q[CHK_IDX*8 +: 8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_frame <= '0;
      out_valid <= 1'b0;
      chk_err   <= 1'b0;
    end else begin
      out_valid <= frame_done && match;
      chk_err   <= frame_done && !match;          // aborts this frame's forward
      if (frame_done && match) out_frame <= frame_q;
    end
  end
endmodule

// File: rtl/frame_hdr_check.sv
module frame_hdr_check #(
  parameter int HDR_BYTES  = 4,
  parameter int BODY_BYTES = 8,
  localparam int NBYTES = HDR_BYTES + BODY_BYTES + 1,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          in_byte,
  input  logic                in_valid,
  output logic [NBYTES*8-1:0] out_frame,
  output logic                out_valid,
  output logic                chk_err
);
  logic [IDX_W-1:0]    pos;
  logic [NBYTES*8-1:0] frame_q;
  logic                frame_done;
  logic [7:0]          hdr_acc;

  frame_collector #(.HDR_BYTES(HDR_BYTES), .BODY_BYTES(BODY_BYTES)) u_col (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .pos(pos), .frame_q(frame_q), .frame_done(frame_done));

  hdr_xor_unit #(.HDR_BYTES(HDR_BYTES), .BODY_BYTES(BODY_BYTES)) u_xor (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .pos(pos), .hdr_acc(hdr_acc));

  fwd_gate #(.HDR_BYTES(HDR_BYTES), .BODY_BYTES(BODY_BYTES)) u_gate (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_q(frame_q),
    .hdr_acc(hdr_acc), .out_frame(out_frame), .out_valid(out_valid), .chk_err(chk_err));
endmodule

// File: rtl/frame_hdr_check_sva.sv
module frame_hdr_check_sva #(
  parameter int HDR_BYTES  = 4,
  parameter int BODY_BYTES = 8,
  localparam int NBYTES = HDR_BYTES + BODY_BYTES + 1,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [IDX_W-1:0] pos,
  input logic             frame_done,
  input logic             out_valid,
  input logic             chk_err
);
  // R3
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= IDX_W'(NBYTES - 1));

  // R2
  idle_holds_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos));

  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (out_valid ^ chk_err));

  // R9
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && chk_err));

  // R6
  fwd_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frame_done));

  // R7
  err_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> $past(frame_done));

  // R6
  fwd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

bind frame_hdr_check frame_hdr_check_sva #(.HDR_BYTES(HDR_BYTES), .BODY_BYTES(BODY_BYTES)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos(pos),
  .frame_done(frame_done), .out_valid(out_valid), .chk_err(chk_err));

// File: tb/sim_frame_hdr_check.sv
module sim_frame_hdr_check;
  localparam int HB = 4;
  localparam int BB = 8;
  localparam int NB = HB + BB + 1;

  typedef struct {
    logic          bad;
    logic [NB*8-1:0] frame;
  } exp_t;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [7:0]      in_byte = 0;
  logic            in_valid = 0;
  logic [NB*8-1:0] out_frame;
  logic            out_valid, chk_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [NB*8-1:0] last_good = '0;

  always #2 clk = ~clk;   // 250 MHz

  frame_hdr_check #(.HDR_BYTES(HB), .BODY_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .out_frame(out_frame), .out_valid(out_valid), .chk_err(chk_err));

  task automatic check(input bit ok, input string req, input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Builds a frame from a seed; the check byte is the header parity unless corrupted.
  function automatic logic [NB*8-1:0] make_frame(input int seed, input logic [7:0] corrupt);
    logic [NB*8-1:0] f;
    logic [7:0] p;
    p = 8'h00;
    for (int k = 0; k < NB - 1; k++) begin
      f[k*8 +: 8] = 8'((seed * 37 + k * 91 + 5) ^ (k << 4));
      if (k < HB) p = p ^ f[k*8 +: 8];
    end
    f[(NB-1)*8 +: 8] = p ^ corrupt;
    return f;
  endfunction

  // Driver: queues the expectation, then feeds the bytes (gap>0 inserts junk idle cycles).
  task automatic send(input logic [NB*8-1:0] f, input bit bad, input int gap);
    exp_t e;
    e.bad = bad; e.frame = f;
    sb.push_back(e);
    for (int k = 0; k < NB; k++) begin
      if (gap > 0 && (k % gap) == 1) begin
        for (int g = 0; g < 2; g++) begin
          @(posedge clk); #1 in_valid = 0; in_byte = 8'hA5 ^ 8'(k + g);  // R2 junk ignored
        end
      end
      @(posedge clk); #1 in_valid = 1; in_byte = f[k*8 +: 8];
    end
    @(posedge clk); #1 in_valid = 0; in_byte = 8'h3C;
  endtask

  // Monitor: scoreboard pop and compare on each pulse, sampled on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (out_valid || chk_err)) begin
        if (sb.size() == 0) begin
          check(0, "R9 unexpected pulse", {out_valid, chk_err}, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.bad) begin
            check(chk_err && !out_valid, "R7 err pulse", {out_valid, chk_err}, 1);
            check(out_frame == last_good, "R7 out_frame held", out_frame, last_good);
          end else begin
            check(out_valid && !chk_err, "R6 R5 fwd pulse", {out_valid, chk_err}, 2);
            check(out_frame == e.frame, "R2 R4 frame contents", out_frame, e.frame);
            last_good = e.frame;
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 0 && chk_err == 0, "R1 pulses low", {out_valid, chk_err}, 0);
    check(out_frame == '0, "R1 frame zero", out_frame, '0);
    rst_n = 1;
    @(posedge clk); #1;

    send(make_frame(1, 8'h00), 0, 0);     // R6 contiguous good frame
    send(make_frame(2, 8'h00), 0, 3);     // R2 idle gaps with junk
    send(make_frame(3, 8'h80), 1, 0);     // R7 R5 bit-7-only corruption
    send(make_frame(4, 8'h00), 0, 0);     // R8 good right after bad
    begin
      logic [NB*8-1:0] f;
      f = make_frame(4, 8'h00);
      for (int k = HB; k < NB - 1; k++) f[k*8 +: 8] = ~f[k*8 +: 8];  // R5 body changes only
      send(f, 0, 0);
    end
    send(make_frame(5, 8'h01), 1, 2);     // R7 low-bit corruption with gaps
    send(make_frame(6, 8'h00), 0, 0);     // R3 frames back to back
    send(make_frame(7, 8'h00), 0, 0);     // R3
    repeat (6) @(posedge clk);
    #1;
    check(sb.size() == 0, "R9 every frame answered", 32'(sb.size()), 0);
    check(out_valid == 0 && chk_err == 0, "R6 pulses ended", {out_valid, chk_err}, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule